// File: doc/BRIEF.md
# Carrier Interrupt and Status Controller

This block is the register and interrupt core of a carrier board that hosts four plug-in modules, each of which can drive two interrupt request lines. Software reaches it through a small 16-bit register port: one control register per slot, a shared status register, a revision register that always reads zero and a reset register that does nothing. The eight module requests are gated by per-line enables, captured into status bits and merged into one host interrupt line.

Each request line is individually set to level or edge behaviour. Level lines hold the host interrupt asserted as long as any of them has its status bit set. An edge line inverts the host line for exactly one cycle when its status bit rises. Software clears timeout flags by writing ones to the status register. It asks a module to drop a request either by writing a one at that request's status position or by reading the module's interrupt-acknowledge location. Both produce a one-cycle clear pulse towards the module.

Top module: `carrier_irq_ctrl`

## Requirements
- R1: After reset all control and status bits are zero, `hostIrq` is low, `regRdData` is zero and no `modClr` bit is set.
- R2: Control registers sit at byte offsets 0x2, 0x4, 0x6, 0x8 for slots 0..3 (slot = offset/2 - 1). A write stores bits 7:0 and a later read returns them with bits 15:8 zero. In a control byte, bits 7:6 enable request lines 1/0 (bit 6+line) and bits 5:4 select edge mode (bit 4+line, 1 = edge). Bits 3:0 are stored only.
- R3: Offset 0x0 (revision) and offset 0xA (reset) always read zero, and writes to them change no register.
- R4: A module request line whose enable bit is clear leaves its status bit unchanged, whatever the request does.
- R5: For an enabled line, status bit slot*2+line (bits 7:0 at offset 0xC) takes the request level at the next clock edge. Register reads are returned one cycle after the read strobe.
- R6: `hostIrq` is high, one cycle after the request is sampled, while any status bit of a level-mode line is set, and low when none is. Edge-mode bits take no part in this test.
- R7: When an edge-mode status bit rises, `hostIrq` is inverted relative to its level value for exactly one cycle. A falling edge-mode bit leaves `hostIrq` unchanged.
- R8: A pulse on `timeoutEvt[s]` sets status bit 12+s. Writing 1 at that bit clears it, and writing 0 leaves it.
- R9: Status bits 11:8 (error field) always read zero, and writes of ones there have no effect.
- R10: A status write with a 1 at request position slot*2+line pulses `modClr` at that position for one cycle, only when `modPresent[slot]` is high.
- R11: An interrupt-space read of a slot at offset 0 acknowledges line 0 and at offset 2 acknowledges line 1. The acknowledge pulses `modClr` only when that status bit is set, the line is in level mode and the slot is present. Other offsets acknowledge nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register byte offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data, valid the cycle after `regRdEn` |
| intRdEn | input | 1 | Read strobe into a module's interrupt space |
| intRdSlot | input | 2 | Slot addressed by the interrupt-space read |
| intRdOffset | input | 6 | Offset within the interrupt space |
| modReq | input | 8 | Module request levels, index slot*2+line |
| modPresent | input | 4 | Module fitted, one per slot |
| timeoutEvt | input | 4 | Timeout event pulses, one per slot |
| modClr | output | 8 | One-cycle clear/acknowledge pulses to modules |
| hostIrq | output | 1 | Merged host interrupt |

## Verification
Status bits, read data, clear pulses and the host interrupt are all registered at the same clock edge that samples their stimulus. So every result is due one edge after the inputs are applied. The bench drives inputs on the falling edge, lets one rising edge pass and samples at the next falling edge. An edge pulse is therefore observed in its only cycle and checked gone one cycle later. Read-back values reflect register contents from before the edge that performs the read, and the stimulus table is ordered with that in mind.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;
  localparam int N_SLOT    = 4;
  localparam int N_LINE    = 2;
  localparam int N_REQ     = N_SLOT * N_LINE;
  localparam int SLOT_W    = $clog2(N_SLOT);
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 4;
  localparam int CTRL_W    = 8;
  localparam int INT_OFF_W = 6;
  localparam int ERR_LO    = N_REQ;
  localparam int ERR_W     = 4;
  localparam int TMO_BASE  = ERR_LO + ERR_W;
  localparam int EDGE_BIT  = 4;
  localparam int EN_BIT    = EDGE_BIT + N_LINE;

  localparam logic [ADDR_W-1:0] CTRL_BASE  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RESET_OFF  = ADDR_W'(2 * (N_SLOT + 1));
  localparam logic [ADDR_W-1:0] STATUS_OFF = ADDR_W'(2 * (N_SLOT + 2));

  typedef enum logic [1:0] {RD_HOLD, RD_ZERO, RD_CTRL, RD_STATUS} rdsel_e;

  typedef struct packed {
    logic [N_SLOT-1:0] ctrlWe;
    logic              statusWe;
    rdsel_e            rdSel;
    logic [SLOT_W-1:0] slotIdx;
    logic [N_SLOT-1:0] ackSlot;
    logic [N_LINE-1:0] ackLine;
  } strobe_t;
endpackage

// File: rtl/carrier_irq_decode.sv
module carrier_irq_decode
  import carrier_irq_pkg::*;
(
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 intRdEn,
  input  logic [SLOT_W-1:0]    intRdSlot,
  input  logic [INT_OFF_W-1:0] intRdOffset,
  output strobe_t              stb
);
  logic              isCtrl;
  logic              isStatus;
  logic [ADDR_W-1:0] slotFull;

  always_comb begin
    isCtrl   = (regAddr >= CTRL_BASE) && (regAddr < RESET_OFF) && !regAddr[0];
    isStatus = (regAddr == STATUS_OFF);
    slotFull = (regAddr >> 1) - ADDR_W'(1);

    stb.slotIdx  = slotFull[SLOT_W-1:0];
    stb.statusWe = regWrEn && isStatus;
    for (int s = 0; s < N_SLOT; s++) begin
      stb.ctrlWe[s]  = regWrEn && isCtrl && (stb.slotIdx == SLOT_W'(s));
      stb.ackSlot[s] = intRdEn && (intRdSlot == SLOT_W'(s));
    end
    for (int l = 0; l < N_LINE; l++) begin
      stb.ackLine[l] = (intRdOffset == INT_OFF_W'(2 * l));
    end

    if (!regRdEn)      stb.rdSel = RD_HOLD;
    else if (isCtrl)   stb.rdSel = RD_CTRL;
    else if (isStatus) stb.rdSel = RD_STATUS;
    else               stb.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/carrier_irq_regs.sv
module carrier_irq_regs
  import carrier_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [N_REQ-1:0]  modReq,
  input  logic [N_SLOT-1:0] modPresent,
  input  logic [N_SLOT-1:0] timeoutEvt,
  output logic [DATA_W-1:0] regRdData,
  output logic [N_REQ-1:0]  modClr,
  output logic              hostIrq,
  output logic [N_REQ-1:0]  intSt,
  output logic [N_SLOT-1:0] tmoSt,
  output logic [N_REQ-1:0]  enMask
);
  logic [CTRL_W-1:0] ctrlQ [N_SLOT];
  logic [N_REQ-1:0]  edgeMask;
  logic [N_REQ-1:0]  presentLine;
  logic [N_REQ-1:0]  ackHit;
  logic [N_REQ-1:0]  intNext;
  logic [N_REQ-1:0]  wrClr;
  logic [N_SLOT-1:0] tmoClr;
  logic [DATA_W-1:0] stWord;
  logic [DATA_W-1:0] rdMux;
  logic              levelQ;
  logic              pulseQ;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
      localparam int IDX = s * N_LINE + l;
      assign enMask[IDX]      = ctrlQ[s][EN_BIT + l];
      assign edgeMask[IDX]    = ctrlQ[s][EDGE_BIT + l];
      assign presentLine[IDX] = modPresent[s];
      assign ackHit[IDX]      = stb.ackSlot[s] & stb.ackLine[l] & intSt[IDX] & ~edgeMask[IDX];
    end
  end

  always_comb begin
    intNext = (modReq & enMask) | (intSt & ~enMask);
    wrClr   = stb.statusWe ? regWrData[N_REQ-1:0] : '0;
    tmoClr  = stb.statusWe ? regWrData[TMO_BASE +: N_SLOT] : '0;

    stWord = '0;
    stWord[N_REQ-1:0]         = intSt;
    stWord[TMO_BASE +: N_SLOT] = tmoSt;

    case (stb.rdSel)
      RD_CTRL:   rdMux = DATA_W'(ctrlQ[stb.slotIdx]);
      RD_STATUS: rdMux = stWord;
      RD_ZERO:   rdMux = '0;
      default:   rdMux = regRdData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < N_SLOT; s++) ctrlQ[s] <= '0;
      intSt     <= '0;
      tmoSt     <= '0;
      modClr    <= '0;
      regRdData <= '0;
      levelQ    <= 1'b0;
      pulseQ    <= 1'b0;
    end else begin
      for (int s = 0; s < N_SLOT; s++) begin
        if (stb.ctrlWe[s]) ctrlQ[s] <= regWrData[CTRL_W-1:0];
      end
      intSt     <= intNext;
      levelQ    <= |(intNext & ~edgeMask);
      pulseQ    <= |(intNext & ~intSt & edgeMask);
      tmoSt     <= (tmoSt & ~tmoClr) | timeoutEvt;
      modClr    <= (wrClr | ackHit) & presentLine;
      regRdData <= rdMux;
    end
  end

  assign hostIrq = levelQ ^ pulseQ;
endmodule

// File: rtl/carrier_irq_ctrl.sv
module carrier_irq_ctrl
  import carrier_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 intRdEn,
  input  logic [SLOT_W-1:0]    intRdSlot,
  input  logic [INT_OFF_W-1:0] intRdOffset,
  input  logic [N_REQ-1:0]     modReq,
  input  logic [N_SLOT-1:0]    modPresent,
  input  logic [N_SLOT-1:0]    timeoutEvt,
  output logic [N_REQ-1:0]     modClr,
  output logic                 hostIrq
);
  strobe_t           stb;
  logic [N_REQ-1:0]  intSt;
  logic [N_SLOT-1:0] tmoSt;
  logic [N_REQ-1:0]  enMask;

  carrier_irq_decode u_decode (
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .intRdEn    (intRdEn),
    .intRdSlot  (intRdSlot),
    .intRdOffset(intRdOffset),
    .stb        (stb)
  );

  carrier_irq_regs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regWrData (regWrData),
    .modReq    (modReq),
    .modPresent(modPresent),
    .timeoutEvt(timeoutEvt),
    .regRdData (regRdData),
    .modClr    (modClr),
    .hostIrq   (hostIrq),
    .intSt     (intSt),
    .tmoSt     (tmoSt),
    .enMask    (enMask)
  );
endmodule

// File: rtl/carrier_irq_ctrl_chk.sv
module carrier_irq_ctrl_chk
  import carrier_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [N_REQ-1:0]  modReq,
  input logic [N_SLOT-1:0] modPresent,
  input logic [N_SLOT-1:0] timeoutEvt,
  input logic [N_REQ-1:0]  modClr,
  input logic [DATA_W-1:0] regRdData,
  input logic [N_REQ-1:0]  intSt,
  input logic [N_SLOT-1:0] tmoSt,
  input logic [N_REQ-1:0]  enMask
);
  logic [N_REQ-1:0] presentLine;
  for (genvar i = 0; i < N_REQ; i++) begin : g_pl
    assign presentLine[i] = modPresent[i / N_LINE];
  end

  // R4: disabled lines keep their status bit
  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (((intSt ^ $past(intSt)) & ~$past(enMask)) == '0));

  // R5: enabled lines follow the sampled request
  a_r5_enabled_track: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (((intSt ^ $past(modReq)) & $past(enMask)) == '0));

  // R8: a timeout event always lands in the status word
  a_r8_timeout_set: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutEvt != '0) |=> ((tmoSt & $past(timeoutEvt)) == $past(timeoutEvt)));

  // R9: error field never reads as set
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[ERR_LO +: ERR_W] == '0);

  // R10, R11: clear pulses only toward fitted modules
  a_r10_clr_present: assert property (@(posedge clk) disable iff (!rstN)
    (modClr != '0) |-> ((modClr & ~$past(presentLine)) == '0));
endmodule

bind carrier_irq_ctrl carrier_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modReq    (modReq),
  .modPresent(modPresent),
  .timeoutEvt(timeoutEvt),
  .modClr    (modClr),
  .regRdData (regRdData),
  .intSt     (intSt),
  .tmoSt     (tmoSt),
  .enMask    (enMask)
);

// File: tb/carrier_irq_ctrl_tb.sv
`timescale 1ns/1ps
module carrier_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, intRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [1:0]  intRdSlot = '0;
  logic [5:0]  intRdOffset = '0;
  logic [7:0]  modReq = '0;
  logic [3:0]  modPresent = '0;
  logic [3:0]  timeoutEvt = '0;
  logic [7:0]  modClr;
  logic        hostIrq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  carrier_irq_ctrl u_dut (.*);

  typedef struct packed {
    logic [1:0]  op;     // 0 idle, 1 write, 2 read
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [7:0]  req;
    logic [15:0] expRd;
    logic        expIrq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 4'h2, 16'h00C0, 8'h00, 16'h0000, 1'b0}, // R2 slot0 level, both enabled
    '{2'd2, 4'h2, 16'h0000, 8'h00, 16'h00C0, 1'b0}, // R2 readback
    '{2'd0, 4'h0, 16'h0000, 8'h01, 16'h0000, 1'b1}, // R6 level rises
    '{2'd2, 4'hC, 16'h0000, 8'h01, 16'h0001, 1'b1}, // R5 status bit 0
    '{2'd0, 4'h0, 16'h0000, 8'h00, 16'h0000, 1'b0}, // R6 level drops
    '{2'd0, 4'h0, 16'h0000, 8'h04, 16'h0000, 1'b0}, // R4 disabled line
    '{2'd2, 4'hC, 16'h0000, 8'h04, 16'h0000, 1'b0}, // R4 status unchanged
    '{2'd1, 4'h4, 16'h0050, 8'h04, 16'h0000, 1'b0}, // R4 enable lands after this edge
    '{2'd0, 4'h0, 16'h0000, 8'h04, 16'h0000, 1'b1}, // R7 edge pulse
    '{2'd0, 4'h0, 16'h0000, 8'h04, 16'h0000, 1'b0}, // R7 pulse gone, edge excluded from level
    '{2'd2, 4'hC, 16'h0000, 8'h04, 16'h0004, 1'b0}, // R5 status bit 2
    '{2'd0, 4'h0, 16'h0000, 8'h00, 16'h0000, 1'b0}, // R7 falling edge no change
    '{2'd0, 4'h0, 16'h0000, 8'h01, 16'h0000, 1'b1}, // R6
    '{2'd0, 4'h0, 16'h0000, 8'h05, 16'h0000, 1'b0}, // R7 inverted dip on high level
    '{2'd0, 4'h0, 16'h0000, 8'h05, 16'h0000, 1'b1}, // R7 back to level
    '{2'd2, 4'h8, 16'h0000, 8'h05, 16'h0000, 1'b1}, // R2 slot3 untouched
    '{2'd1, 4'h0, 16'hFFFF, 8'h05, 16'h0000, 1'b1}, // R3 revision write
    '{2'd1, 4'hA, 16'hFFFF, 8'h05, 16'h0000, 1'b1}, // R3 reset write
    '{2'd2, 4'h0, 16'h0000, 8'h05, 16'h0000, 1'b1}, // R3 revision reads zero
    '{2'd2, 4'hA, 16'h0000, 8'h05, 16'h0000, 1'b1}, // R3 reset reads zero
    '{2'd2, 4'h2, 16'h0000, 8'h05, 16'h00C0, 1'b1}, // R3 slot0 control kept
    '{2'd0, 4'h0, 16'h0000, 8'h00, 16'h0000, 1'b0}, // R6 R7 all low
    '{2'd1, 4'h6, 16'hAB3C, 8'h00, 16'h0000, 1'b0}, // R2 upper byte dropped
    '{2'd2, 4'h6, 16'h0000, 8'h00, 16'h003C, 1'b0}  // R2 reads low byte only
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the next rising edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0; intRdEn = 1'b0; timeoutEvt = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
  endtask

  task automatic rd(input logic [3:0] a);
    regAddr = a; regRdEn = 1'b1;
    tick();
  endtask

  task automatic ack(input logic [1:0] s, input logic [5:0] off);
    intRdSlot = s; intRdOffset = off; intRdEn = 1'b1;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hostIrq == 1'b0, "R1 hostIrq", hostIrq, 0);
    check(regRdData == 16'h0, "R1 regRdData", regRdData, 0);
    check(modClr == 8'h0, "R1 modClr", modClr, 0);
    rd(4'hC);
    check(regRdData == 16'h0, "R1 status", regRdData, 0);

    for (int i = 0; i < NV; i++) begin
      modReq = VEC[i].req;
      regAddr = VEC[i].addr;
      regWrData = VEC[i].wdata;
      regWrEn = (VEC[i].op == 2'd1);
      regRdEn = (VEC[i].op == 2'd2);
      tick();
      check(hostIrq == VEC[i].expIrq, $sformatf("R6/R7 vec %0d hostIrq", i),
            hostIrq, VEC[i].expIrq);
      if (VEC[i].op == 2'd2)
        check(regRdData == VEC[i].expRd, $sformatf("R2/R3/R5 vec %0d rd", i),
              regRdData, VEC[i].expRd);
    end

    // R8 timeout set and clear, R9 error field
    timeoutEvt = 4'b0101;
    tick();
    rd(4'hC);
    check(regRdData == 16'h5000, "R8 timeout set", regRdData, 16'h5000);
    wr(4'hC, 16'h1000);
    rd(4'hC);
    check(regRdData == 16'h4000, "R8 timeout clear", regRdData, 16'h4000);
    wr(4'hC, 16'h0F00);
    rd(4'hC);
    check(regRdData == 16'h4000, "R9 error write ignored", regRdData, 16'h4000);

    // R10 clear by status write
    modPresent = 4'b0001;
    wr(4'hC, 16'h0003);
    check(modClr == 8'h03, "R10 clear present", modClr, 8'h03);
    tick();
    check(modClr == 8'h00, "R10 single cycle", modClr, 0);
    wr(4'hC, 16'h000C);
    check(modClr == 8'h00, "R10 absent slot", modClr, 0);

    // R11 acknowledge reads
    modPresent = 4'b1111;
    modReq = 8'h05;
    tick();
    ack(2'd0, 6'd0);
    check(modClr == 8'h01, "R11 level ack line0", modClr, 8'h01);
    ack(2'd1, 6'd0);
    check(modClr == 8'h00, "R11 edge no ack", modClr, 0);
    ack(2'd0, 6'd2);
    check(modClr == 8'h00, "R11 line1 not set", modClr, 0);
    ack(2'd0, 6'd4);
    check(modClr == 8'h00, "R11 other offset", modClr, 0);
    modPresent = 4'b1110;
    ack(2'd0, 6'd0);
    check(modClr == 8'h00, "R11 absent slot", modClr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule